// File: doc/BRIEF.md
# Constant-Rate Obfuscated Request Issuer

This block sits on the processor side of an encrypted memory link that serves a secure application. It accepts read and write requests from the application and turns each one into a link packet of fixed length. Every packet carries a full data field. A read fills that field with zeros, so reads and writes look the same on the wire. Each packet is XORed with a one-time-pad word before it leaves the block. The pad words are computed outside the block and arrive on an input port that follows a sequence index published by the block.

Only one transaction is outstanding at a time. Once a response is back, it is decrypted with the next pad in the sequence. The next issue slot then opens a fixed number of cycles after the cycle in which the response was taken. At that slot the block sends the request held in its one-entry holding register, if there is one. Otherwise it sends a dummy read, so the link carries packets at a rate that does not depend on what the application does. A response to a real request is handed back as a one-cycle completion. A response to a dummy is decrypted, consumes its pad, and is then dropped.

Top module: `obf_req_issuer`

## Requirements
- R1: The cleartext packet is PKT_W = 1+ADDR_W+DATA_W bits wide:
  - bit PKT_W-1 is the access type (1 = write, 0 = read);
  - the next ADDR_W bits down hold the address;
  - the low DATA_W bits hold the data.
  
  The `tx_pkt` value is that cleartext XOR the `pad_word` present while `pad_seq` shows the index being used.
- R2: A read request is sent with its data field all zeros, whatever `req_wdata` carried.
- R3: An issue (`tx_valid` high) appears exactly GAP_CYCLES clock edges after the edge that took the previous response.
- R4: If the holding register is empty at an issue slot, a dummy packet is sent. Its cleartext has type 0, address 0 and data 0. The response to a dummy raises no `cpl_valid`.
- R5: `pad_seq` is 0 after reset. It increments by one at each issue and by one at each accepted response, so each transaction uses exactly two pads.
- R6: After the response to a real request, `cpl_valid` is high for exactly one cycle, on the edge that took the response. At the same time `cpl_pkt` = `rx_pkt` XOR `pad_word`.
- R7: After reset is released, the first issue happens on the first clock edge, with no GAP_CYCLES wait.
- R8: The `tx_valid` signal is a one-cycle pulse. A `rx_valid` that arrives while no transaction is outstanding is ignored: `pad_seq` does not change and no completion is raised.
- R9: The holding register has one entry. `req_ready` is high only while it is empty, and a request offered while `req_ready` is low is not taken. A request accepted while a response is awaited goes out in the next issue slot.
- R10: During and right after reset, `tx_valid` = 0, `cpl_valid` = 0, `pad_seq` = 0 and `req_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Application request offered |
| req_ready | output | 1 | Holding register empty; request taken when both are high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data (ignored for reads) |
| pad_seq | output | SEQ_W | Index of the pad the block needs next |
| pad_word | input | PKT_W | Pad for index `pad_seq`, valid in the same cycle |
| tx_valid | output | 1 | One-cycle strobe: `tx_pkt` holds an outgoing encrypted packet |
| tx_pkt | output | PKT_W | Encrypted outgoing packet |
| rx_valid | input | 1 | Encrypted response present |
| rx_pkt | input | PKT_W | Encrypted response packet |
| cpl_valid | output | 1 | Completion for a real request |
| cpl_pkt | output | PKT_W | Decrypted response packet |

## Verification
The assertions make three assumptions about the block's inputs:
- the link never returns a response in the same cycle that the issue strobe is first visible;
- `pad_word` always follows `pad_seq` combinationally;
- stray responses outside a transaction may occur and must be ignored.

The stimulus stays within these assumptions in the following ways:
- The link model drives each response at least two clock edges after it sees the issue.
- The pad word is computed in the bench as an arithmetic function of `pad_seq`.
- Requests, late requests, decoy requests offered while `req_ready` is low, and stray responses are all placed between sample points away from the clock edge.

// File: rtl/obf_pkg.sv
// Package: shared types of the obfuscated request issuer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package obf_pkg;

    // Issue sequencer state: waiting for the slot, or waiting for a response.
    typedef enum logic [0:0] {
        ST_GAP  = 1'b0,
        ST_WAIT = 1'b1
    } issue_st_t;

endpackage

// File: rtl/obf_hold_slot.sv
// Module: one-entry request holding register.
// Takes a request on valid/ready and keeps it until the issuer takes it.
// Assumes take is raised only while the slot is full.
module obf_hold_slot #(
    parameter int ADDR_W = 63,
    parameter int DATA_W = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_write,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic              take,
    output logic              full,
    output logic              out_write,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_wdata
);

    assign in_ready = !full;

    // Fill on an accepted request, empty when the issuer takes the entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full      <= 1'b0;
            out_write <= 1'b0;
            out_addr  <= '0;
            out_wdata <= '0;
        end else if (in_valid && in_ready) begin
            full      <= 1'b1;
            out_write <= in_write;
            out_addr  <= in_addr;
            out_wdata <= in_wdata;
        end else if (take) begin
            full <= 1'b0;
        end
    end

endmodule

// File: rtl/obf_slot_timer.sv
// Module: issue slot timer.
// Opens a slot GAP_CYCLES edges after a restart; open at once after reset.
// Assumes GAP_CYCLES >= 1 and that restart does not coincide with fire.
module obf_slot_timer #(
    parameter int GAP_CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic fire
);

    localparam int CNT_W = $clog2(GAP_CYCLES) + 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(GAP_CYCLES - 1);

    logic             run_q;
    logic [CNT_W-1:0] cnt_q;

    assign fire = run_q && (cnt_q == '0);

    // Count down while running; stop once the slot fires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (restart) begin
            run_q <= 1'b1;
            cnt_q <= LOAD;
        end else if (fire) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/obf_pad_seq.sv
// Module: pad sequence index.
// Advances by one each time a pad word is consumed; cleared by reset.
// Assumes the index may wrap at 2**SEQ_W.
module obf_pad_seq #(
    parameter int SEQ_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [SEQ_W-1:0] seq
);

    // Step the index once per consumed pad.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq <= '0;
        end else if (step) begin
            seq <= seq + 1'b1;
        end
    end

endmodule

// File: rtl/obf_req_issuer.sv
// Module: constant-rate obfuscated request issuer (top).
// Holds one application request and sends it, or a dummy read, at each slot.
// Every packet has a full data field and is XORed with a pad. Each response
// is decrypted with the next pad. Assumes pad_word follows pad_seq in the
// same cycle and that one response is returned per issued packet.
module obf_req_issuer
    import obf_pkg::*;
#(
    parameter int ADDR_W     = 63,
    parameter int DATA_W     = 512,
    parameter int GAP_CYCLES = 50,
    parameter int SEQ_W      = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic [SEQ_W-1:0]         pad_seq,
    input  logic [ADDR_W+DATA_W:0]   pad_word,
    output logic                     tx_valid,
    output logic [ADDR_W+DATA_W:0]   tx_pkt,
    input  logic                     rx_valid,
    input  logic [ADDR_W+DATA_W:0]   rx_pkt,
    output logic                     cpl_valid,
    output logic [ADDR_W+DATA_W:0]   cpl_pkt
);

    localparam int PKT_W = 1 + ADDR_W + DATA_W;

    issue_st_t         state_q;
    logic              real_q;
    logic              hold_full;
    logic              hold_write;
    logic [ADDR_W-1:0] hold_addr;
    logic [DATA_W-1:0] hold_wdata;
    logic              slot_fire;
    logic              issue_go;
    logic              rsp_go;
    logic [PKT_W-1:0]  clear_pkt;

    assign issue_go = (state_q == ST_GAP) && slot_fire;
    assign rsp_go   = (state_q == ST_WAIT) && rx_valid;

    obf_hold_slot #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_valid),
        .in_ready  (req_ready),
        .in_write  (req_write),
        .in_addr   (req_addr),
        .in_wdata  (req_wdata),
        .take      (issue_go && hold_full),
        .full      (hold_full),
        .out_write (hold_write),
        .out_addr  (hold_addr),
        .out_wdata (hold_wdata)
    );

    obf_slot_timer #(
        .GAP_CYCLES (GAP_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (rsp_go),
        .fire    (slot_fire)
    );

    obf_pad_seq #(
        .SEQ_W (SEQ_W)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (issue_go || rsp_go),
        .seq   (pad_seq)
    );

    // Build the cleartext: the held request, reads zero-filled, else a dummy read.
    always_comb begin
        clear_pkt = '0;
        if (hold_full) begin
            clear_pkt[PKT_W-1]              = hold_write;
            clear_pkt[PKT_W-2 -: ADDR_W]    = hold_addr;
            clear_pkt[DATA_W-1:0]           = hold_write ? hold_wdata : '0;
        end
    end

    // Sequence issue and response handling; outputs are registered strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_GAP;
            real_q    <= 1'b0;
            tx_valid  <= 1'b0;
            tx_pkt    <= '0;
            cpl_valid <= 1'b0;
            cpl_pkt   <= '0;
        end else begin
            tx_valid  <= 1'b0;
            cpl_valid <= 1'b0;
            if (issue_go) begin
                tx_valid <= 1'b1;
                tx_pkt   <= clear_pkt ^ pad_word;
                real_q   <= hold_full;
                state_q  <= ST_WAIT;
            end else if (rsp_go) begin
                cpl_valid <= real_q;
                cpl_pkt   <= rx_pkt ^ pad_word;
                state_q   <= ST_GAP;
            end
        end
    end

endmodule

// File: rtl/obf_req_issuer_chk.sv
// Module: assertion checker for obf_req_issuer, attached by bind.
// Tracks the outstanding transaction and the distance from the last response.
// Assumes no response arrives in the cycle the issue strobe first appears.
module obf_req_issuer_chk #(
    parameter int GAP_CYCLES = 50,
    parameter int SEQ_W      = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             tx_valid,
    input logic             rx_valid,
    input logic             cpl_valid,
    input logic [SEQ_W-1:0] pad_seq
);

    localparam int CW = $clog2(GAP_CYCLES + 2) + 1;
    localparam logic [CW-1:0] SAT = CW'(GAP_CYCLES + 1);

    logic          outst_q;
    logic          seen_q;
    logic [CW-1:0] gap_q;

    // Model of the outstanding transaction and of the cycles since its response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst_q <= 1'b0;
            seen_q  <= 1'b0;
            gap_q   <= '0;
        end else begin
            outst_q <= tx_valid || (outst_q && !rx_valid);
            if (rx_valid && outst_q) begin
                seen_q <= 1'b1;
                gap_q  <= '0;
            end else if (gap_q != SAT) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    assert_tx_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> !tx_valid);

    assert_single_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !outst_q);

    assert_fixed_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && seen_q) |-> (gap_q == CW'(GAP_CYCLES)));

    assert_seq_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pad_seq) |-> (pad_seq == $past(pad_seq) + 1'b1));

    assert_issue_uses_pad_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !$stable(pad_seq));

    assert_cpl_after_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> ($past(rx_valid) && $past(outst_q)));

    assert_hold_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

bind obf_req_issuer obf_req_issuer_chk #(
    .GAP_CYCLES (GAP_CYCLES),
    .SEQ_W      (SEQ_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .tx_valid  (tx_valid),
    .rx_valid  (rx_valid),
    .cpl_valid (cpl_valid),
    .pad_seq   (pad_seq)
);

// File: tb/obf_req_issuer_test.sv
// Bench: sweeps request kinds, response delays, late and decoy requests and
// stray responses over a small configuration; expected packets are computed
// arithmetically from the pad function and the request values.
module obf_req_issuer_test;

    localparam int AW    = 7;
    localparam int DW    = 8;
    localparam int GAP   = 5;
    localparam int SW    = 8;
    localparam int PW    = 1 + AW + DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [SW-1:0] pad_seq;
    logic [PW-1:0] pad_word;
    logic          tx_valid;
    logic [PW-1:0] tx_pkt;
    logic          rx_valid = 1'b0;
    logic [PW-1:0] rx_pkt = '0;
    logic          cpl_valid;
    logic [PW-1:0] cpl_pkt;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rx_cyc = 0;
    int exp_seq = 0;
    bit done = 1'b0;

    bit            pend_v = 1'b0;
    bit            pend_wr = 1'b0;
    logic [AW-1:0] pend_addr = '0;
    logic [DW-1:0] pend_data = '0;

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [PW-1:0] pad_of(input int s);
        logic [7:0] hi;
        logic [7:0] lo;
        hi = 8'(s * 59) ^ 8'hC6;
        lo = 8'(s * 157 + 53);
        return {hi, lo};
    endfunction

    assign pad_word = pad_of(int'(pad_seq));

    obf_req_issuer #(
        .ADDR_W     (AW),
        .DATA_W     (DW),
        .GAP_CYCLES (GAP),
        .SEQ_W      (SW)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .pad_seq   (pad_seq),
        .pad_word  (pad_word),
        .tx_valid  (tx_valid),
        .tx_pkt    (tx_pkt),
        .rx_valid  (rx_valid),
        .rx_pkt    (rx_pkt),
        .cpl_valid (cpl_valid),
        .cpl_pkt   (cpl_pkt)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic offer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        chk(req_ready == 1'b1, "R9 ready while empty", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R9 ready low while full", int'(req_ready), 0);
        pend_v    = 1'b1;
        pend_wr   = wr;
        pend_addr = a;
        pend_data = d;
    endtask

    task automatic do_txn(input bit sub, input bit s_wr, input logic [AW-1:0] s_addr,
                          input logic [DW-1:0] s_data, input bit late, input int delay,
                          input logic [PW-1:0] rsp_clear, input bit stray, input bit first);
        int            wcnt;
        bit            real_exp;
        logic [PW-1:0] exp_clear;
        if (sub) offer(s_wr, s_addr, s_data);
        wcnt = 0;
        while (!tx_valid && wcnt < 100) begin
            @(negedge clk);
            wcnt++;
        end
        if (first) chk(wcnt == 1, "R7 immediate first issue", wcnt, 1);
        else chk(cyc - rx_cyc == GAP, "R3 issue gap", cyc - rx_cyc, GAP);
        exp_clear = '0;
        if (pend_v) exp_clear = {pend_wr, pend_addr, pend_wr ? pend_data : 8'h00};
        if (!pend_v) chk(tx_pkt == (exp_clear ^ pad_of(exp_seq)), "R4 dummy packet",
                         int'(tx_pkt), int'(exp_clear ^ pad_of(exp_seq)));
        else if (pend_wr) chk(tx_pkt == (exp_clear ^ pad_of(exp_seq)), "R1 write packet",
                              int'(tx_pkt), int'(exp_clear ^ pad_of(exp_seq)));
        else chk(tx_pkt == (exp_clear ^ pad_of(exp_seq)), "R2 read packet zero data",
                 int'(tx_pkt), int'(exp_clear ^ pad_of(exp_seq)));
        real_exp = pend_v;
        pend_v   = 1'b0;
        exp_seq++;
        chk(int'(pad_seq) == (exp_seq % 256), "R5 seq after issue", int'(pad_seq), exp_seq % 256);
        if (real_exp) chk(req_ready == 1'b1, "R9 ready after issue", int'(req_ready), 1);
        @(negedge clk);
        chk(tx_valid == 1'b0, "R8 tx pulse", int'(tx_valid), 0);
        if (late) begin
            offer(~s_wr, s_addr ^ 7'h55, s_data ^ 8'h3C);
            req_valid = 1'b1;
            req_write = s_wr;
            req_addr  = ~s_addr;
            req_wdata = ~s_data;
            @(negedge clk);
            req_valid = 1'b0;
        end
        repeat (delay - 1) @(negedge clk);
        rx_valid = 1'b1;
        rx_pkt   = rsp_clear ^ pad_of(exp_seq);
        @(negedge clk);
        rx_valid = 1'b0;
        rx_cyc   = cyc;
        if (real_exp) begin
            chk(cpl_valid == 1'b1, "R6 completion raised", int'(cpl_valid), 1);
            chk(cpl_pkt == rsp_clear, "R6 decrypted response", int'(cpl_pkt), int'(rsp_clear));
        end else begin
            chk(cpl_valid == 1'b0, "R4 dummy gives no completion", int'(cpl_valid), 0);
        end
        exp_seq++;
        chk(int'(pad_seq) == (exp_seq % 256), "R5 seq after response", int'(pad_seq), exp_seq % 256);
        if (stray) begin
            rx_valid = 1'b1;
            rx_pkt   = 16'hFFFF;
            @(negedge clk);
            rx_valid = 1'b0;
            chk(cpl_valid == 1'b0, "R8 stray response ignored", int'(cpl_valid), 0);
            chk(int'(pad_seq) == (exp_seq % 256), "R8 stray keeps seq", int'(pad_seq), exp_seq % 256);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(tx_valid == 1'b0, "R10 reset tx_valid", int'(tx_valid), 0);
        chk(cpl_valid == 1'b0, "R10 reset cpl_valid", int'(cpl_valid), 0);
        chk(pad_seq == '0, "R10 reset pad_seq", int'(pad_seq), 0);
        chk(req_ready == 1'b1, "R10 reset req_ready", int'(req_ready), 1);
        rst_n = 1'b1;
        do_txn(1'b0, 1'b0, '0, '0, 1'b0, 2, 16'h1234, 1'b0, 1'b1);
        for (int i = 0; i < 150; i++) begin
            bit sub;
            sub = (i % 3 != 1) && !pend_v;
            do_txn(sub, 1'(i), 7'(i * 13), 8'(i * 29 + 7), (i % 7 == 3),
                   1 + (i % 4), 16'(i * 4111 + 99), (i % 5 == 2), 1'b0);
        end
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule